// File: doc/BRIEF.md
# Gain Soft-Step Controller

This block owns the gain codes of six audio gain stages (volume, speaker, loudness, treble, middle, bass). A new setting never appears as a jump. The stage's code walks toward it over a timed transition, so neither a DC offset nor a sudden signal change turns into an audible click. Control bytes arrive through a byte-wide write port with a stage select. Each byte carries a target code and a flag. The flag either starts a transition or parks the new target until a later byte starts one.

One shared sequencer times all transitions. Every parked stage starts together with the stage whose byte starts the transition. Transitions never overlap: a start request that arrives during a transition waits until that transition has finished. The duration is a single global choice of a short or long time. It is split into `N_STEPS` equal intervals. At each interval boundary a ramping stage moves its code by one toward the target, and on the last boundary it lands exactly on the target. A stage whose soft-step enable bit is clear jumps straight to its target when a transition starts.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) sets every gain code to 0, clears every parked stage and any start request, and drives `busy` low.
- R2: A write carries the target code in `wr_data[CODE_W-1:0]` and the flag in `wr_data[CODE_W]`, where 0 means start and 1 means park. Stage selects 0 to 5 address volume, speaker, loudness, treble, middle and bass. A select of `N_STAGES` or above is ignored and changes neither a code nor `busy`.
- R3: Let L = CLK_KHZ*T/N_STEPS cycles, where T is 5 ms when `long_time` is 0 and 10 ms when it is 1, sampled at the start edge. `busy` stays high for exactly N_STEPS*L cycles.
- R4: When the block is idle, a start write launches the transition on the next clock edge. `busy` therefore rises one cycle after the write edge, provided at least one launched stage is enabled.
- R5: A ramping stage changes its code only at interval boundaries, every L cycles after launch. It moves one code toward its target at each boundary and takes the exact target on the last one.
- R6: A park write changes no gain code and does not raise `busy`.
- R7: On launch, every parked stage starts its transition on the same edge.
- R8: A launched stage whose `ramp_en` bit is 0 takes its target on the launch edge. Its start write still launches the other parked stages.
- R9: A start write during a transition records its target and keeps the request. The request launches on the first edge after `busy` falls, so `busy` is low for exactly one cycle in between.
- R10: A second park write to an already parked stage replaces the held target. Only the latest target is used at launch.
- R11: A stage that is not parked at launch keeps its code through the whole transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one control byte |
| wr_sel | input | 3 | Stage select |
| wr_data | input | 8 | Flag (MSB) and target code |
| long_time | input | 1 | 0 selects the 5 ms transition, 1 selects 10 ms |
| ramp_en | input | 6 | Per-stage soft-step enable |
| gain_out | output | 42 | Current codes, stage s at bits [s*7 +: 7] |
| busy | output | 1 | Transition in progress |

## Verification
A lost or stale parked flag shows up at launch: a stage that should move stays still, or a stage that should stay still moves. The bench sees this on the first cycle after the launch edge. A wrong interval counter shifts the code changes off the L-cycle grid and makes the `busy` pulse the wrong length, which shows within one interval. A dropped start request during a transition leaves `busy` low after it falls, and the bench reports that one cycle later. A missing final snap leaves a code short of its target when `busy` drops.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;

   // flag carried in the top bit of every control byte
   typedef enum logic {
      ACT_START = 1'b0,
      ACT_PARK  = 1'b1
   } act_flag_e;

   // stage numbering seen on wr_sel
   typedef enum logic [2:0] {
      STG_VOLUME   = 3'd0,
      STG_SPEAKER  = 3'd1,
      STG_LOUDNESS = 3'd2,
      STG_TREBLE   = 3'd3,
      STG_MIDDLE   = 3'd4,
      STG_BASS     = 3'd5
   } stage_id_e;

   function automatic int unsigned width_for(int unsigned count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/gain_ramp_wdec.sv
module gain_ramp_wdec
   import gain_ramp_pkg::*;
#(
   parameter int N_STAGES = 6,
   parameter int CODE_W   = 7,
   parameter int SEL_W    = 3
) (
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic [CODE_W:0]     wr_data,
   output logic [N_STAGES-1:0] hit,
   output logic [CODE_W-1:0]   code,
   output logic                start
);

   logic      in_range;
   act_flag_e flag;

   assign in_range = wr_en && (int'(wr_sel) < N_STAGES);
   assign flag     = act_flag_e'(wr_data[CODE_W]);
   assign code     = wr_data[CODE_W-1:0];

   always_comb begin
      hit = '0;
      if (in_range) hit = N_STAGES'(1) << wr_sel;
   end

   assign start = in_range && (flag == ACT_START);

endmodule

// File: rtl/gain_ramp_timer.sv
module gain_ramp_timer #(
   parameter int SHORT_LEN = 10,
   parameter int LONG_LEN  = 20,
   parameter int N_STEPS   = 16,
   localparam int CNT_W    = $clog2(LONG_LEN + 1),
   localparam int STEP_W   = $clog2(N_STEPS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic long_sel,
   output logic busy,
   output logic tick,
   output logic last
);

   logic [CNT_W-1:0]  cnt_q;
   logic [STEP_W-1:0] idx_q;
   logic              long_q;
   logic              busy_q;
   logic              final_idx;
   logic [CNT_W-1:0]  reload;

   assign reload = long_q ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1);

   // last-interval detect: a plain AND for power-of-two step counts
   if ((N_STEPS & (N_STEPS - 1)) == 0) begin : g_pow2
      assign final_idx = &idx_q;
   end else begin : g_cmp
      assign final_idx = (idx_q == STEP_W'(N_STEPS - 1));
   end

   assign busy = busy_q;
   assign tick = busy_q && (cnt_q == '0);
   assign last = tick && final_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         idx_q  <= '0;
         long_q <= 1'b0;
      end else if (launch) begin
         busy_q <= 1'b1;
         long_q <= long_sel;
         idx_q  <= '0;
         cnt_q  <= long_sel ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1);
      end else if (tick) begin
         if (final_idx) begin
            busy_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
            cnt_q <= reload;
         end
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/gain_ramp_lane.sv
module gain_ramp_lane #(
   parameter int CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [CODE_W-1:0] code,
   input  logic              launch,
   input  logic              ramp_en,
   input  logic              tick,
   input  logic              last,
   output logic [CODE_W-1:0] gain,
   output logic              parked
);

   logic [CODE_W-1:0] cur_q;
   logic [CODE_W-1:0] held_q;
   logic [CODE_W-1:0] dest_q;
   logic              park_q;
   logic              move_q;

   assign gain   = cur_q;
   assign parked = park_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         held_q <= '0;
         dest_q <= '0;
         park_q <= 1'b0;
         move_q <= 1'b0;
      end else begin
         // launch: ramp if enabled, else jump
         if (launch && park_q) begin
            park_q <= 1'b0;
            if (ramp_en) begin
               move_q <= 1'b1;
               dest_q <= held_q;
            end else begin
               cur_q <= held_q;
            end
         end
         // interval boundary: unit step, exact landing on the last one
         if (tick && move_q) begin
            if (last) begin
               cur_q  <= dest_q;
               move_q <= 1'b0;
            end else if (cur_q < dest_q) begin
               cur_q <= cur_q + 1'b1;
            end else if (cur_q > dest_q) begin
               cur_q <= cur_q - 1'b1;
            end
         end
         // a new byte always wins over a same-cycle launch
         if (hit) begin
            held_q <= code;
            park_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
   import gain_ramp_pkg::*;
#(
   parameter int N_STAGES = 6,
   parameter int CODE_W   = 7,
   parameter int CLK_KHZ  = 125000,
   parameter int SHORT_MS = 5,
   parameter int LONG_MS  = 10,
   parameter int N_STEPS  = 16,
   localparam int SEL_W   = int'(width_for(N_STAGES))
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           wr_sel,
   input  logic [CODE_W:0]            wr_data,
   input  logic                       long_time,
   input  logic [N_STAGES-1:0]        ramp_en,
   output logic [N_STAGES*CODE_W-1:0] gain_out,
   output logic                       busy
);

   localparam int SHORT_LEN = CLK_KHZ * SHORT_MS / N_STEPS;
   localparam int LONG_LEN  = CLK_KHZ * LONG_MS / N_STEPS;

   if (N_STAGES < 1) begin : g_bad_stages
      $error("gain_ramp_ctrl: N_STAGES must be at least 1");
   end
   if (N_STEPS < 2) begin : g_bad_steps
      $error("gain_ramp_ctrl: N_STEPS must be at least 2");
   end
   if (SHORT_LEN < 1) begin : g_bad_len
      $error("gain_ramp_ctrl: short interval rounds to zero cycles");
   end
   if (LONG_MS < SHORT_MS) begin : g_bad_order
      $error("gain_ramp_ctrl: LONG_MS below SHORT_MS");
   end

   logic [N_STAGES-1:0] hit;
   logic [CODE_W-1:0]   code;
   logic                wr_start;
   logic [N_STAGES-1:0] parked;
   logic                req_q;
   logic                launch;
   logic                timer_go;
   logic                tick;
   logic                last;

   gain_ramp_wdec #(
      .N_STAGES (N_STAGES),
      .CODE_W   (CODE_W),
      .SEL_W    (SEL_W)
   ) u_wdec (
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .hit     (hit),
      .code    (code),
      .start   (wr_start)
   );

   // single request latch shared by all stages
   assign launch   = req_q && !busy;
   assign timer_go = launch && |(parked & ramp_en);

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= (req_q && !launch) || wr_start;
   end

   gain_ramp_timer #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN),
      .N_STEPS   (N_STEPS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (timer_go),
      .long_sel (long_time),
      .busy     (busy),
      .tick     (tick),
      .last     (last)
   );

   for (genvar s = 0; s < N_STAGES; s++) begin : g_lane
      gain_ramp_lane #(
         .CODE_W (CODE_W)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit     (hit[s]),
         .code    (code),
         .launch  (launch),
         .ramp_en (ramp_en[s]),
         .tick    (tick),
         .last    (last),
         .gain    (gain_out[s*CODE_W +: CODE_W]),
         .parked  (parked[s])
      );
   end

endmodule

// File: rtl/gain_ramp_chk.sv
module gain_ramp_chk #(
   parameter int N_STAGES  = 6,
   parameter int CODE_W    = 7,
   parameter int N_STEPS   = 16,
   parameter int SHORT_LEN = 10,
   parameter int LONG_LEN  = 20
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       long_time,
   input logic                       busy,
   input logic [N_STAGES*CODE_W-1:0] gain_out
);

   logic                       rst_q;
   logic                       busy_q;
   logic                       lt_q;
   logic [N_STAGES*CODE_W-1:0] gain_q;
   int unsigned                idx_q;
   int unsigned                phase_q;
   int unsigned                len_q;

   always_ff @(posedge clk) begin
      rst_q  <= !rst_n;
      lt_q   <= long_time;
      gain_q <= gain_out;
      if (rst_q === 1'b1 && rst_n) begin
         assert_reset_clear_R1: assert (!busy && gain_out == '0)
            else $error("R1: state not cleared by reset");
      end
      if (!rst_n) begin
         busy_q  <= 1'b0;
         idx_q   <= 0;
         phase_q <= 0;
         len_q   <= 1;
      end else begin
         busy_q <= busy;
         if (busy && !busy_q) begin
            idx_q   <= 1;
            len_q   <= lt_q ? LONG_LEN : SHORT_LEN;
            phase_q <= ((lt_q ? LONG_LEN : SHORT_LEN) == 1) ? 0 : 1;
         end else if (busy) begin
            idx_q   <= idx_q + 1;
            phase_q <= (phase_q == len_q - 1) ? 0 : phase_q + 1;
         end
         if (!busy && busy_q) begin
            assert_busy_length_R3: assert (idx_q == N_STEPS * len_q)
               else $error("R3: busy lasted %0d cycles", idx_q);
         end
         if (busy && busy_q && gain_out != gain_q) begin
            assert_step_on_interval_R5: assert (phase_q == 0)
               else $error("R5: code changed off an interval boundary");
         end
      end
   end

   for (genvar g = 0; g < N_STAGES; g++) begin : g_step
      logic [CODE_W-1:0] now_v;
      logic [CODE_W-1:0] was_v;
      assign now_v = gain_out[g*CODE_W +: CODE_W];
      assign was_v = gain_q[g*CODE_W +: CODE_W];
      always_ff @(posedge clk) begin
         if (rst_n && busy && busy_q && now_v != was_v) begin
            assert_unit_step_R5: assert (now_v == was_v + 1'b1 || was_v == now_v + 1'b1)
               else $error("R5: stage %0d moved by more than one code", g);
         end
      end
   end

endmodule

bind gain_ramp_ctrl gain_ramp_chk #(
   .N_STAGES  (N_STAGES),
   .CODE_W    (CODE_W),
   .N_STEPS   (N_STEPS),
   .SHORT_LEN (SHORT_LEN),
   .LONG_LEN  (LONG_LEN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .long_time (long_time),
   .busy      (busy),
   .gain_out  (gain_out)
);

// File: tb/gain_ramp_ctrl_test.sv
module gain_ramp_ctrl_test;

   localparam int NS      = 6;
   localparam int CW      = 7;
   localparam int KHZ     = 16;
   localparam int STEPS   = 8;
   localparam int L_SHORT = KHZ * 5 / STEPS;
   localparam int L_LONG  = KHZ * 10 / STEPS;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               wr_en = 1'b0;
   logic [2:0]         wr_sel = '0;
   logic [CW:0]        wr_data = '0;
   logic               long_time = 1'b0;
   logic [NS-1:0]      ramp_en = '1;
   logic [NS*CW-1:0]   gain_out;
   logic               busy;

   always #4 clk = ~clk;

   gain_ramp_ctrl #(
      .N_STAGES (NS),
      .CODE_W   (CW),
      .CLK_KHZ  (KHZ),
      .N_STEPS  (STEPS)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .long_time (long_time),
      .ramp_en   (ramp_en),
      .gain_out  (gain_out),
      .busy      (busy)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference model
   int m_cur [NS];
   int m_tgt [NS];
   bit m_park [NS];
   bit m_req;
   int r_start [NS];
   int r_end [NS];
   bit r_on [NS];
   bit r_jump [NS];

   function automatic int gain_of(int s);
      return int'(gain_out[s*CW +: CW]);
   endfunction

   function automatic int step_toward(int a, int b, int m);
      if (b > a) return (a + m > b) ? b : a + m;
      return (a - m < b) ? b : a - m;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_model(string req, string what);
      for (int s = 0; s < NS; s++)
         check(gain_of(s) == m_cur[s], req, what, gain_of(s), m_cur[s]);
   endtask

   // one control byte, driven from a falling edge for one cycle
   task automatic put(int sel, bit park, int code);
      wr_en   = 1'b1;
      wr_sel  = sel[2:0];
      wr_data = {park, code[CW-1:0]};
      @(negedge clk);
      wr_en = 1'b0;
      if (sel < NS) begin
         m_tgt[sel]  = code;
         m_park[sel] = 1'b1;
         if (!park) m_req = 1'b1;
      end
   endtask

   // launch happens on the next rising edge; follow the ramp to its end
   task automatic run_ramp(bit inj, int inj_at, int inj_sel, bit inj_park, int inj_code);
      bit any;
      int len, total, c, e;
      len = long_time ? L_LONG : L_SHORT;
      any = 1'b0;
      for (int s = 0; s < NS; s++) begin
         r_on[s]   = 1'b0;
         r_jump[s] = 1'b0;
         if (m_park[s]) begin
            if (ramp_en[s]) begin
               r_on[s]    = 1'b1;
               r_start[s] = m_cur[s];
               r_end[s]   = m_tgt[s];
               any        = 1'b1;
            end else begin
               m_cur[s]  = m_tgt[s];
               r_jump[s] = 1'b1;
            end
            m_park[s] = 1'b0;
         end
      end
      m_req = 1'b0;
      total = any ? STEPS * len : 0;
      @(negedge clk);
      check(busy == any, "R4", "busy one cycle after start", int'(busy), int'(any));
      c = 0;
      while (busy && c < total + 5) begin
         for (int s = 0; s < NS; s++) begin
            if (r_on[s]) begin
               e = step_toward(r_start[s], r_end[s], c / len);
               check(gain_of(s) == e, "R5", "ramp code", gain_of(s), e);
            end else if (r_jump[s]) begin
               check(gain_of(s) == m_cur[s], "R8", "direct load", gain_of(s), m_cur[s]);
            end else begin
               check(gain_of(s) == m_cur[s], "R11", "idle stage held", gain_of(s), m_cur[s]);
            end
         end
         if (inj && c == inj_at) begin
            wr_en   = 1'b1;
            wr_sel  = inj_sel[2:0];
            wr_data = {inj_park, inj_code[CW-1:0]};
            if (inj_sel < NS) begin
               m_tgt[inj_sel]  = inj_code;
               m_park[inj_sel] = 1'b1;
               if (!inj_park) m_req = 1'b1;
            end
         end else begin
            wr_en = 1'b0;
         end
         c++;
         @(negedge clk);
      end
      wr_en = 1'b0;
      check(c == total, "R3", "busy length", c, total);
      for (int s = 0; s < NS; s++) begin
         if (r_on[s]) m_cur[s] = r_end[s];
         r_on[s] = 1'b0;
      end
      check_model("R5", "landed on target");
   endtask

   task automatic follow_pending();
      if (m_req) begin
         check(busy == 1'b0, "R9", "gap before queued launch", int'(busy), 0);
         run_ramp(1'b0, 0, 0, 1'b0, 0);
      end
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R3 watchdog: actual still running expected completion");
      finish_run();
   end

   initial begin
      int n_park, sel;
      void'($urandom(32'd5417));
      for (int s = 0; s < NS; s++) begin
         m_cur[s] = 0; m_tgt[s] = 0; m_park[s] = 1'b0;
      end
      m_req = 1'b0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
      check_model("R1", "code in reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R4/R5/R3: single start, short time, remainder on the last step
      put(0, 1'b0, 40);
      run_ramp(1'b0, 0, 0, 1'b0, 0);

      // R3: long time, small move that lands early
      long_time = 1'b1;
      put(1, 1'b0, 5);
      run_ramp(1'b0, 0, 0, 1'b0, 0);
      long_time = 1'b0;

      // R6/R10/R7: parked stages, replaced target, joint launch
      put(2, 1'b1, 100);
      put(3, 1'b1, 20);
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R6", "no busy after park", int'(busy), 0);
      check_model("R6", "park leaves code");
      put(3, 1'b1, 30);
      check_model("R10", "replace leaves code");
      put(5, 1'b0, 60);
      run_ramp(1'b0, 0, 0, 1'b0, 0);
      check(gain_of(3) == 30, "R10", "latest held target used", gain_of(3), 30);
      check(gain_of(2) == 100, "R7", "parked stage ramped", gain_of(2), 100);

      // R8: disabled stage jumps, still launches a parked one
      ramp_en = 6'b101111;
      put(0, 1'b1, 10);
      put(4, 1'b0, 90);
      run_ramp(1'b0, 0, 0, 1'b0, 0);

      // R8: only a disabled stage, no transition at all
      put(4, 1'b0, 3);
      run_ramp(1'b0, 0, 0, 1'b0, 0);
      ramp_en = '1;

      // R2: selects beyond the last stage are ignored
      put(6, 1'b0, 77);
      put(7, 1'b1, 12);
      repeat (2) @(negedge clk);
      check(busy == 1'b0, "R2", "busy after bad select", int'(busy), 0);
      check_model("R2", "code after bad select");

      // R9: start write during a running transition
      put(1, 1'b0, 120);
      run_ramp(1'b1, 30, 2, 1'b0, 7);
      follow_pending();
      check(gain_of(2) == 7, "R9", "queued target reached", gain_of(2), 7);

      // random mix
      for (int it = 0; it < 24; it++) begin
         ramp_en   = NS'($urandom);
         long_time = 1'($urandom);
         n_park    = int'($urandom_range(0, 3));
         for (int k = 0; k < n_park; k++)
            put(int'($urandom_range(0, 7)), 1'b1, int'($urandom_range(0, 127)));
         check(busy == 1'b0, "R6", "random park idle", int'(busy), 0);
         check_model("R6", "random park code");
         sel = int'($urandom_range(0, NS - 1));
         put(sel, 1'b0, int'($urandom_range(0, 127)));
         if (it % 3 == 0)
            run_ramp(1'b1, int'($urandom_range(0, 70)), int'($urandom_range(0, 7)),
                     1'($urandom), int'($urandom_range(0, 127)));
         else
            run_ramp(1'b0, 0, 0, 1'b0, 0);
         follow_pending();
      end

      finish_run();
   end

endmodule